// File: doc/BRIEF.md
# Receive Queue with Error-Tally Status Register

This block sits behind a serial receiver. Each received byte arrives with two error tags: a parity-error tag and a framing-error tag. The block stores the byte and its tags in a first-in, first-out queue that holds 16 entries. The oldest entry is always visible on `head_byte`, and a pop removes it.

A 16-bit status word is readable at all times. Its upper byte gives two live tallies: the number of queued entries that carry a parity error (bits 15:12) and the number that carry a framing error (bits 11:8). Its lower byte holds eight flags:

| Bit | Flag |
|-----|------|
| 7 | error seen |
| 6 | transmit end |
| 5 | transmit room |
| 4 | line break |
| 3 | head framing error |
| 2 | head parity error |
| 1 | receive threshold |
| 0 | data ready |

Software acknowledges a flag in two steps. It must first read the flag as 1, then write 0 to it. The transmit, break and data-ready events come in as single-cycle pulses from neighbouring logic.

A push into a full queue is discarded and raises a sticky overrun output. A standby input exists so that the block can be parked with the rest of the chip. It leaves every stored value untouched.

Top module: `rxq_errstat`

## Requirements
- R1: While `rst` is high at a clock edge, the state returns to its initial values. After reset, `reg_rdata` reads 0x0060 (transmit end = 1, transmit room = 1, everything else 0), `overrun` is 0, the queue is empty and `head_byte` is 0.
- R2: Bytes leave the queue in the order in which they were accepted. `head_byte` shows the oldest stored byte, and shows 0 while the queue is empty.
- R3: Bits 15:12 equal the number of queued entries whose parity tag is set, modulo 16. Bits 11:8 equal the same count for framing tags. A full queue of tagged entries therefore reads 0. A push and a pop of tagged entries in the same cycle leave the count unchanged.
- R4: Bit 3 equals the framing tag of the head entry, and bit 2 equals its parity tag. Both bits are 0 while the queue is empty.
- R5: Bit 7 sets on an accepted push whose byte carries either tag. Bit 6 sets on `tx_end_pulse`, bit 5 on `tx_empty_pulse`, bit 4 on `brk_pulse` and bit 0 on `dr_pulse`. Each flag is set from the next cycle onward.
- R6: Bit 1 sets in the cycle after the occupancy rises from `RDF_TRIG`-1 to `RDF_TRIG` (default 8).
- R7: Writing 1 to bit 7, 6, 5, 4, 1 or 0 leaves that bit unchanged.
- R8: Writing 0 to bit 7, 6, 5, 4, 1 or 0 clears that bit only if a read (`reg_rd`) has seen the bit as 1 in an earlier cycle since it was last set. Otherwise the bit keeps its value.
- R9: Writes have no effect on bits 15:8, 3 and 2.
- R10: A push while 16 entries are held is dropped and sets `overrun`, which stays at 1 until reset. A pop on an empty queue changes nothing.
- R11: `standby` has no effect on any stored value or output.
- R12: If a set event for a flag and a clearing write to that flag happen in the same cycle, the flag stays at 1. It must then be read again before a write of 0 can clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | Park request; no effect on state |
| rx_valid | input | 1 | Push a received byte |
| rx_byte | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity-error tag of the received byte |
| rx_frm_err | input | 1 | Framing-error tag of the received byte |
| pop | input | 1 | Remove the head entry |
| tx_end_pulse | input | 1 | Sets the transmit end flag (bit 6) |
| tx_empty_pulse | input | 1 | Sets the transmit room flag (bit 5) |
| brk_pulse | input | 1 | Sets the line break flag (bit 4) |
| dr_pulse | input | 1 | Sets the data ready flag (bit 0) |
| reg_rd | input | 1 | Status read strobe; arms flags read as 1 |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 16 | Status write data |
| reg_rdata | output | 16 | Current status word |
| head_byte | output | 8 | Oldest queued byte, 0 when empty |
| overrun | output | 1 | Sticky push-while-full indication |

## Verification
The tallies are driven with a mix of byte patterns: parity only, framing only, both tags and no tag. This mix shows whether each tag feeds its own count and whether the head-tag bits follow the entry that actually sits at the head. A run of 16 doubly tagged bytes, followed by one extra push, separates correct modulo-16 reporting and correct dropping from a counter that saturates or an entry that gets overwritten. A push and a pop of tagged bytes in the same cycle shows whether the increment and decrement cancel. The acknowledge handshake is tried as a write without a prior read, a write of all ones after a read, a write of 0 after a read, and a write of 0 that coincides with a set pulse. These four cases tell apart a correctly armed clear, a clear that is missing, and a clear that fires too early.

// File: rtl/rxq_errstat_pkg.sv
package rxq_errstat_pkg;

    localparam int BYTE_W      = 8;
    localparam int CNT_FIELD_W = 4;
    localparam int FLAG_W      = 8;
    localparam int STAT_W      = 2 * CNT_FIELD_W + FLAG_W;

    // Flag positions inside the low byte of the status word.
    localparam int FB_DR   = 0;
    localparam int FB_RDF  = 1;
    localparam int FB_PER  = 2;
    localparam int FB_FER  = 3;
    localparam int FB_BRK  = 4;
    localparam int FB_TDFE = 5;
    localparam int FB_TEND = 6;
    localparam int FB_ER   = 7;

    // Values the flags take after reset.
    localparam logic [FLAG_W-1:0] FLAG_RST = 8'h60;

    // One queued entry: the byte plus its two error tags.
    typedef struct packed {
        logic              perr;
        logic              ferr;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    // Flags that follow the head entry instead of holding state.
    function automatic logic is_live_flag(input int idx);
        return (idx == FB_PER) || (idx == FB_FER);
    endfunction

    // Build the status word from the two tallies and the flags.
    function automatic logic [STAT_W-1:0] pack_status(
        input logic [CNT_FIELD_W-1:0] par_cnt,
        input logic [CNT_FIELD_W-1:0] frm_cnt,
        input logic [FLAG_W-1:0]      flags
    );
        return {par_cnt, frm_cnt, flags};
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_errstat_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int OW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic          pop_req,
    input  rx_entry_t     wr_entry,
    output rx_entry_t     head,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [OW-1:0] occ,
    output logic [OW-1:0] occ_nxt,
    output logic          full,
    output logic          empty
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [OW-1:0] DEPTH_V  = OW'(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Pointer advance that also works for depths that are not a power of two.
    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    assign full    = (occ == DEPTH_V);
    assign empty   = (occ == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;
    assign occ_nxt = occ + OW'(push_ok) - OW'(pop_ok);
    assign head    = mem[rd_ptr];

    // Storage: no reset, only written on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= step_ptr(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= step_ptr(rd_ptr);
            end
            occ <= occ_nxt;
        end
    end

endmodule

// File: rtl/rxq_tag_tally.sv
module rxq_tag_tally #(
    parameter int OW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [OW-1:0] cnt
);

    // Tagged entries in flight: up on a tagged push, down on a tagged pop.
    // A push and a pop in the same cycle cancel.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + OW'(inc) - OW'(dec);
        end
    end

endmodule

// File: rtl/rxq_ack_flag.sv
module rxq_ack_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic rd_ev,
    input  logic wr_ev,
    input  logic wr_bit,
    output logic q
);

    // armed: the flag has been read as 1 since it was last set.
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= RST_VAL;
            armed <= 1'b0;
        end else if (set_ev) begin
            // A set event wins over a clear and demands a fresh read.
            q     <= 1'b1;
            armed <= 1'b0;
        end else if (wr_ev && !wr_bit && armed) begin
            q     <= 1'b0;
            armed <= 1'b0;
        end else if (rd_ev && q) begin
            armed <= 1'b1;
        end
    end

endmodule

// File: rtl/rxq_errstat.sv
module rxq_errstat
    import rxq_errstat_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int RDF_TRIG = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              pop,
    input  logic              tx_end_pulse,
    input  logic              tx_empty_pulse,
    input  logic              brk_pulse,
    input  logic              dr_pulse,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] head_byte,
    output logic              overrun
);

    localparam int OW = $clog2(DEPTH) + 1;
    localparam logic [OW-1:0] TRIG_V = OW'(RDF_TRIG);

    rx_entry_t       wr_entry;
    rx_entry_t       head;
    logic            push_ok;
    logic            pop_ok;
    logic [OW-1:0]   occ;
    logic [OW-1:0]   occ_nxt;
    logic            full;
    logic            empty;
    logic [OW-1:0]   par_cnt;
    logic [OW-1:0]   frm_cnt;
    logic            er_ev;
    logic            rdf_ev;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] flag_q;
    logic            head_perr;
    logic            head_ferr;

    assign wr_entry = '{perr: rx_par_err, ferr: rx_frm_err, data: rx_byte};

    rxq_store #(
        .DEPTH (DEPTH)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .push_req (rx_valid),
        .pop_req  (pop),
        .wr_entry (wr_entry),
        .head     (head),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .occ      (occ),
        .occ_nxt  (occ_nxt),
        .full     (full),
        .empty    (empty)
    );

    rxq_tag_tally #(
        .OW (OW)
    ) u_par_tally (
        .clk (clk),
        .rst (rst),
        .inc (push_ok && rx_par_err),
        .dec (pop_ok && head.perr),
        .cnt (par_cnt)
    );

    rxq_tag_tally #(
        .OW (OW)
    ) u_frm_tally (
        .clk (clk),
        .rst (rst),
        .inc (push_ok && rx_frm_err),
        .dec (pop_ok && head.ferr),
        .cnt (frm_cnt)
    );

    assign head_perr = !empty && head.perr;
    assign head_ferr = !empty && head.ferr;
    assign head_byte = empty ? '0 : head.data;

    // Set events for the flags that hold state.
    assign er_ev  = push_ok && (rx_par_err || rx_frm_err);
    assign rdf_ev = (occ < TRIG_V) && (occ_nxt >= TRIG_V);

    always_comb begin
        set_vec          = '0;
        set_vec[FB_ER]   = er_ev;
        set_vec[FB_TEND] = tx_end_pulse;
        set_vec[FB_TDFE] = tx_empty_pulse;
        set_vec[FB_BRK]  = brk_pulse;
        set_vec[FB_RDF]  = rdf_ev;
        set_vec[FB_DR]   = dr_pulse;
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        if (is_live_flag(i)) begin : g_live
            assign flag_q[i] = (i == FB_PER) ? head_perr : head_ferr;
        end else begin : g_ack
            rxq_ack_flag #(
                .RST_VAL (FLAG_RST[i])
            ) u_flag (
                .clk    (clk),
                .rst    (rst),
                .set_ev (set_vec[i]),
                .rd_ev  (reg_rd),
                .wr_ev  (reg_wr),
                .wr_bit (reg_wdata[i]),
                .q      (flag_q[i])
            );
        end
    end

    // Sticky: only reset clears it.
    always_ff @(posedge clk) begin
        if (rst) begin
            overrun <= 1'b0;
        end else if (rx_valid && full) begin
            overrun <= 1'b1;
        end
    end

    assign reg_rdata = pack_status(par_cnt[CNT_FIELD_W-1:0],
                                   frm_cnt[CNT_FIELD_W-1:0],
                                   flag_q);

    // Read-only write bits, the standby request and the two unused set slots go nowhere.
    logic [FLAG_W+4:0] sink_unused;
    assign sink_unused = {reg_wdata[STAT_W-1:FLAG_W], reg_wdata[FB_FER], reg_wdata[FB_PER],
                          set_vec[FB_FER], set_vec[FB_PER], standby};

endmodule

// File: rtl/rxq_errstat_chk.sv
module rxq_errstat_chk (
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic        rx_par_err,
    input logic        rx_frm_err,
    input logic        pop,
    input logic        tx_end_pulse,
    input logic        tx_empty_pulse,
    input logic        brk_pulse,
    input logic        dr_pulse,
    input logic        reg_wr,
    input logic        wr_tend_bit,
    input logic [15:0] reg_rdata,
    input logic        overrun,
    input logic        fifo_full
);

    AST_RESET_VALUE: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (reg_rdata == 16'h0060 && !overrun)); // R1

    AST_OVERRUN_RAISE: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && fifo_full) |=> overrun); // R10

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R10

    AST_ER_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !fifo_full && (rx_par_err || rx_frm_err)) |=> reg_rdata[7]); // R5

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        tx_end_pulse |=> reg_rdata[6]); // R12

    AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && wr_tend_bit && reg_rdata[6]) |=> reg_rdata[6]); // R7

    AST_TALLY_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !rx_valid && !pop) |=> $stable(reg_rdata[15:8])); // R9

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && !pop && !reg_wr && !tx_end_pulse && !tx_empty_pulse
         && !brk_pulse && !dr_pulse) |=> $stable(reg_rdata)); // R11

endmodule

bind rxq_errstat rxq_errstat_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .rx_valid       (rx_valid),
    .rx_par_err     (rx_par_err),
    .rx_frm_err     (rx_frm_err),
    .pop            (pop),
    .tx_end_pulse   (tx_end_pulse),
    .tx_empty_pulse (tx_empty_pulse),
    .brk_pulse      (brk_pulse),
    .dr_pulse       (dr_pulse),
    .reg_wr         (reg_wr),
    .wr_tend_bit    (reg_wdata[6]),
    .reg_rdata      (reg_rdata),
    .overrun        (overrun),
    .fifo_full      (full)
);

// File: tb/rxq_errstat_tb_top.sv
module rxq_errstat_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int TRIG       = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        standby = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_par_err = 1'b0;
    logic        rx_frm_err = 1'b0;
    logic        pop = 1'b0;
    logic        tx_end_pulse = 1'b0;
    logic        tx_empty_pulse = 1'b0;
    logic        brk_pulse = 1'b0;
    logic        dr_pulse = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  head_byte;
    logic        overrun;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxq_errstat #(
        .DEPTH    (DEPTH),
        .RDF_TRIG (TRIG)
    ) dut_i (
        .clk            (clk),
        .rst            (rst),
        .standby        (standby),
        .rx_valid       (rx_valid),
        .rx_byte        (rx_byte),
        .rx_par_err     (rx_par_err),
        .rx_frm_err     (rx_frm_err),
        .pop            (pop),
        .tx_end_pulse   (tx_end_pulse),
        .tx_empty_pulse (tx_empty_pulse),
        .brk_pulse      (brk_pulse),
        .dr_pulse       (dr_pulse),
        .reg_rd         (reg_rd),
        .reg_wr         (reg_wr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .head_byte      (head_byte),
        .overrun        (overrun)
    );

    int vec_cnt = 0;
    int bad_cnt = 0;

    // Scoreboard queue of expected entries {perr, ferr, data}, plus the flag model.
    logic [9:0] sb_q[$];
    logic [7:0] m_flag = 8'h60;
    logic [7:0] m_arm  = 8'h00;
    logic       m_ovr  = 1'b0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_upper();
        logic [3:0] pc = '0;
        logic [3:0] fc = '0;
        foreach (sb_q[k]) begin
            pc += {3'b0, sb_q[k][9]};
            fc += {3'b0, sb_q[k][8]};
        end
        return {pc, fc};
    endfunction

    function automatic logic [1:0] exp_head_tags();
        if (sb_q.size() == 0) return 2'b00;
        return {sb_q[0][8], sb_q[0][9]};
    endfunction

    // Per-cycle comparison of every observable field.
    task automatic check_all();
        chk("R3 tallies", {8'h00, reg_rdata[15:8]}, {8'h00, exp_upper()});
        chk("R4 head tags", {14'h0, reg_rdata[3:2]}, {14'h0, exp_head_tags()});
        chk("R8 flag state", {8'h00, reg_rdata[7:0] & 8'hF3}, {8'h00, m_flag & 8'hF3});
        chk("R10 overrun", {15'h0, overrun}, {15'h0, m_ovr});
        chk("R2 head byte", {8'h00, head_byte},
            {8'h00, (sb_q.size() == 0) ? 8'h00 : sb_q[0][7:0]});
    endtask

    // One clock cycle with the given stimulus; pul = {tend, tdfe, brk, dr}.
    task automatic cyc(input logic psh, input logic [7:0] d, input logic pe, input logic fe,
                       input logic pp, input logic rd, input logic wr,
                       input logic [15:0] wd, input logic [3:0] pul, input logic sb);
        int sz;
        int nsz;
        logic push_ok;
        logic pop_ok;
        logic [7:0] setv;
        rx_valid = psh; rx_byte = d; rx_par_err = pe; rx_frm_err = fe;
        pop = pp; reg_rd = rd; reg_wr = wr; reg_wdata = wd;
        tx_end_pulse = pul[3]; tx_empty_pulse = pul[2]; brk_pulse = pul[1]; dr_pulse = pul[0];
        standby = sb;
        sz      = sb_q.size();
        push_ok = psh && (sz < DEPTH);
        pop_ok  = pp && (sz > 0);
        nsz     = sz + int'(push_ok) - int'(pop_ok);
        setv    = {push_ok && (pe || fe), pul[3], pul[2], pul[1], 2'b00,
                   (sz < TRIG) && (nsz >= TRIG), pul[0]};
        // Monitor side of the scoreboard: a popped byte must match the oldest queued one.
        if (pop_ok) chk("R2 pop order", {8'h00, head_byte}, {8'h00, sb_q[0][7:0]});
        for (int i = 0; i < 8; i++) begin
            if (i == 2 || i == 3) continue;
            if (setv[i]) begin
                m_flag[i] = 1'b1; m_arm[i] = 1'b0;
            end else if (wr && !wd[i] && m_arm[i]) begin
                m_flag[i] = 1'b0; m_arm[i] = 1'b0;
            end else if (rd && m_flag[i]) begin
                m_arm[i] = 1'b1;
            end
        end
        if (psh && sz == DEPTH) m_ovr = 1'b1;
        if (pop_ok) void'(sb_q.pop_front());
        if (push_ok) sb_q.push_back({pe, fe, d});
        @(posedge clk);
        #1;
        rx_valid = 0; pop = 0; reg_rd = 0; reg_wr = 0; reg_wdata = '0;
        tx_end_pulse = 0; tx_empty_pulse = 0; brk_pulse = 0; dr_pulse = 0; standby = 0;
        check_all();
    endtask

    task automatic push(input logic [7:0] d, input logic pe, input logic fe);
        cyc(1'b1, d, pe, fe, 1'b0, 1'b0, 1'b0, 16'h0, 4'h0, 1'b0);
    endtask
    task automatic popc();
        cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 4'h0, 1'b0);
    endtask
    task automatic rdc();
        cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 4'h0, 1'b0);
    endtask
    task automatic wrc(input logic [15:0] v);
        cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, v, 4'h0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        sb_q.delete();
        m_flag = 8'h60; m_arm = 8'h00; m_ovr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        bad_cnt++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 reset word", reg_rdata, 16'h0060);
        chk("R1 reset overrun", {15'h0, overrun}, 16'h0);
        chk("R1 reset head", {8'h0, head_byte}, 16'h0);

        // R11: standby held, nothing changes.
        for (int i = 0; i < 4; i++) cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 4'h0, 1'b1);
        chk("R11 standby no effect", reg_rdata, 16'h0060);

        // Mixed tag patterns.
        push(8'hA5, 1'b1, 1'b0);
        push(8'h3C, 1'b0, 1'b1);
        push(8'h7E, 1'b1, 1'b1);
        push(8'h11, 1'b0, 1'b0);
        push(8'h02, 1'b1, 1'b0);
        chk("R5 ER set and tallies", reg_rdata, 16'h32E4);

        wrc(16'h0000);
        chk("R8 no clear without read", reg_rdata, 16'h32E4);
        rdc();
        wrc(16'hFFFF);
        chk("R7 write ones keeps flags", reg_rdata, 16'h32E4);
        chk("R9 tally bits ignore writes", {8'h0, reg_rdata[15:8]}, 16'h0032);
        wrc(16'h0000);
        chk("R8 cleared after read", reg_rdata, 16'h3204);

        cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 4'b1000, 1'b0);
        chk("R5 TEND set", reg_rdata, 16'h3244);
        cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 4'b0011, 1'b0);
        chk("R5 BRK and DR set", reg_rdata, 16'h3255);

        // R12: read arms, then clear write coincides with a TEND set pulse.
        rdc();
        cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 4'b1000, 1'b0);
        chk("R12 set beats clear", reg_rdata, 16'h3244);
        wrc(16'h0000);
        chk("R12 needs fresh read", reg_rdata, 16'h3244);

        popc();
        chk("R4 head framing tag", {14'h0, reg_rdata[3:2]}, 16'h0002);
        repeat (4) popc();
        chk("R4 empty tags zero", {14'h0, reg_rdata[3:2]}, 16'h0000);
        chk("R3 empty tallies zero", {8'h0, reg_rdata[15:8]}, 16'h0000);
        popc();
        chk("R10 pop on empty", {8'h0, head_byte}, 16'h0000);

        // R3: tagged push and pop in one cycle.
        push(8'h40, 1'b1, 1'b0);
        cyc(1'b1, 8'h41, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 4'h0, 1'b0);
        chk("R3 push pop balance", {12'h0, reg_rdata[15:12]}, 16'h0001);
        popc();

        // R6 and R3 wrap: fill with doubly tagged bytes.
        for (int i = 0; i < DEPTH; i++) begin
            push(8'h80 + 8'(i), 1'b1, 1'b1);
            if (i == TRIG - 2) chk("R6 RDF below trigger", {15'h0, reg_rdata[1]}, 16'h0);
            if (i == TRIG - 1) chk("R6 RDF at trigger", {15'h0, reg_rdata[1]}, 16'h1);
        end
        chk("R3 full tally reads zero", {8'h0, reg_rdata[15:8]}, 16'h0000);
        push(8'hEE, 1'b0, 1'b0);
        chk("R10 overrun on full push", {15'h0, overrun}, 16'h0001);
        for (int i = 0; i < DEPTH; i++) popc();
        chk("R10 dropped byte absent", {8'h0, head_byte}, 16'h0000);
        chk("R10 overrun sticky", {15'h0, overrun}, 16'h0001);

        do_reset();
        chk("R1 reset clears overrun", {15'h0, overrun}, 16'h0);
        chk("R1 reset word again", reg_rdata, 16'h0060);

        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

endmodule